// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one SDRAM read or write command into the stream of column addresses that the burst visits, one address per clock cycle. The command supplies the starting column. A mode setting supplies the burst length (1, 2, 4 or 8 beats, or a full page) and the ordering (sequential or interleaved). For each beat the block raises a valid flag with the column address, and it marks the final beat of any finite burst. A terminate strobe, driven by the controller when it issues a precharge, stops a burst early. A new read or write command replaces any burst in progress. A single-write setting shortens every write to one beat and leaves reads at the programmed length.

The mode inputs are sampled together with the command and held for the whole burst. The first beat appears in the cycle after the command is accepted. The data path, the CAS latency delay and bank decoding are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `beat_valid` and `beat_last` are 0.
- R2: `len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The reserved codes 4, 5 and 6 give 1 beat. Beat 0 is presented in the cycle after `cmd_start`, and one further beat follows every cycle.
- R3: With `ileave` = 0 and a finite length BL, beat n presents the start column with its low log2(BL) bits replaced by (low bits + n) mod BL. The upper bits stay equal to the start column.
- R4: With `ileave` = 1 and a finite length BL, beat n presents the start column with its low log2(BL) bits XORed with n.
- R5: A full-page burst presents start + n modulo 512 on beat n, whatever `ileave` is set to. It continues without end until it is terminated or replaced.
- R6: `beat_last` is 1 exactly on the final beat of a finite burst, and `beat_valid` is 0 in the cycle after that beat when no new command arrives. `beat_last` is never 1 during a full-page burst.
- R7: When `term` is asserted without `cmd_start`, `beat_valid` is 0 in the following cycle. `term` while idle leaves the outputs idle.
- R8: When `single_wr` = 1, a write command (`cmd_write` = 1) produces exactly one beat, with `beat_last` = 1, for any `len_code`. This includes full page. Reads keep the programmed length. When `single_wr` = 0, writes use the programmed length.
- R9: A `cmd_start` during a burst restarts the sequence at the new column with the new settings in the next cycle. When `cmd_start` and `term` arrive together, the start takes effect.
- R10: Changes to `len_code`, `ileave` or `single_wr` during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| len_code | input | 3 | Burst length setting, sampled at `cmd_start` |
| ileave | input | 1 | 1 = interleaved ordering, 0 = sequential, sampled at `cmd_start` |
| single_wr | input | 1 | 1 = writes are one beat long, sampled at `cmd_start` |
| cmd_start | input | 1 | Read or write command accepted this cycle |
| cmd_write | input | 1 | The command is a write |
| cmd_col | input | 9 | Starting column of the command |
| term | input | 1 | Terminate the burst in progress (precharge) |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_col | output | 9 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final beat of a finite burst |

## Verification
The assertions assume that `cmd_start`, `term` and the mode inputs are known (never X) after reset. The step checks for full-page bursts assume that only `cmd_start` or `term` interrupts a burst. The stimulus changes inputs only between clock edges and keeps all strobes at 0 except in the cycles where a command or a terminate is intended. Every sweep therefore exercises the assumed conditions exactly. The sweeps cover each length code, both orderings and several start columns, including columns near the top of the page. A long full-page run crosses the 511-to-0 wrap.

// File: rtl/bcg_pkg.sv
// Shared definitions for the burst column address generator.
// Assumes: length codes as listed in the brief; other codes are reserved.
package bcg_pkg;
    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // Width of the log2 burst length value for a given column width.
    function automatic int lg_width(input int col_w);
        return $clog2(col_w + 1);
    endfunction
endpackage

// File: rtl/bcg_mode_decode.sv
// Mode decode: turns the length code, ordering bit and single-write setting
// into the low-bit mask that the burst walks and a full-page flag.
// Assumes: inputs are sampled by the caller together with the command.
module bcg_mode_decode #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code,
    input  logic             ileave,
    input  logic             is_write,
    input  logic             single_wr,
    output logic [COL_W-1:0] mask,
    output logic             full,
    output logic             ileave_eff
);
    import bcg_pkg::*;

    localparam int LGW = lg_width(COL_W);

    logic             one_beat_wr;
    logic [LGW-1:0]   len_lg;

    // Decide the log2 burst length for finite codes.
    always_comb begin
        one_beat_wr = is_write && single_wr;
        full        = (len_code == LEN_PAGE) && !one_beat_wr;
        len_lg      = '0;
        if (!one_beat_wr) begin
            case (len_code)
                LEN_2:   len_lg = LGW'(1);
                LEN_4:   len_lg = LGW'(2);
                LEN_8:   len_lg = LGW'(3);
                default: len_lg = '0;
            endcase
        end
        ileave_eff = ileave && !full;
    end

    // Build the low-bit mask one bit at a time.
    for (genvar b = 0; b < COL_W; b++) begin : g_mask
        assign mask[b] = full || (LGW'(b) < len_lg);
    end
endmodule

// File: rtl/bcg_beat_counter.sv
// Beat counter: tracks whether a burst is running, which beat it is on,
// and whether the current beat is the final one of a finite burst.
// Assumes: mask_in is a contiguous run of low ones; start wins over term.
module bcg_beat_counter #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    output logic             active,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output logic             last
);
    // Final beat of a finite burst.
    assign last = active && !full_q && (beat_idx == mask_q);

    // Advance, restart or stop the burst once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat_idx <= '0;
            mask_q   <= '0;
            full_q   <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            beat_idx <= '0;
            mask_q   <= mask_in;
            full_q   <= full_in;
        end else if (term) begin
            active   <= 1'b0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end
            beat_idx <= beat_idx + 1'b1;
        end
    end

    // R2: a finite burst never counts past its length.
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !full_q) |-> (beat_idx <= mask_q));

    // R6: after the final beat, the burst stops unless restarted.
    a_r6_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);
endmodule

// File: rtl/bcg_addr_order.sv
// Address ordering: forms the column of a beat from the start column, the
// beat index and the mask, in sequential or interleaved order.
// Assumes: bits outside the mask keep the start column unchanged.
module bcg_addr_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ileave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    // Sequential offset; carries out of the mask are discarded per bit below.
    always_comb seq_sum = base + idx;

    // Choose the source of each column bit.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = !mask[b] ? base[b]
                      : (ileave ? (base[b] ^ idx[b]) : seq_sum[b]);
    end
endmodule

// File: rtl/burst_col_gen.sv
// Burst column address generator top: captures the command and mode,
// then presents one column per cycle until the burst ends or is cut.
// Assumes: cmd_start and term are single-cycle strobes from the controller.
module burst_col_gen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       len_code,
    input  logic             ileave,
    input  logic             single_wr,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             term,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ileave;
    logic [COL_W-1:0] base_q;
    logic             ileave_q;
    logic             active;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             last;

    bcg_mode_decode #(.COL_W(COL_W)) u_decode (
        .len_code   (len_code),
        .ileave     (ileave),
        .is_write   (cmd_write),
        .single_wr  (single_wr),
        .mask       (dec_mask),
        .full       (dec_full),
        .ileave_eff (dec_ileave)
    );

    // Hold the start column and ordering for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            ileave_q <= 1'b0;
        end else if (cmd_start) begin
            base_q   <= cmd_col;
            ileave_q <= dec_ileave;
        end
    end

    bcg_beat_counter #(.COL_W(COL_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .term     (term),
        .mask_in  (dec_mask),
        .full_in  (dec_full),
        .active   (active),
        .beat_idx (beat_idx),
        .mask_q   (mask_q),
        .full_q   (full_q),
        .last     (last)
    );

    bcg_addr_order #(.COL_W(COL_W)) u_order (
        .base   (base_q),
        .idx    (beat_idx),
        .mask   (mask_q),
        .ileave (ileave_q),
        .col    (beat_col)
    );

    assign beat_valid = active;
    assign beat_last  = last;

    // R6: the last flag only accompanies a valid beat.
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R6: no last flag while a full page is running.
    a_r6_no_last_page: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !beat_last);

    // R7: a terminate without a command empties the output next cycle.
    a_r7_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd_start) |=> !beat_valid);

    // R9: a command always yields its own start column as beat 0.
    a_r9_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (beat_valid && beat_col == $past(cmd_col)));

    // R5: an undisturbed full page steps by one column per cycle.
    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && full_q && !cmd_start && !term)
        |=> (beat_valid && beat_col == COL_W'($past(beat_col) + 1'b1)));
endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] len_code = 3'd0;
    logic       ileave = 1'b0;
    logic       single_wr = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [8:0] cmd_col = 9'd0;
    logic       term = 1'b0;
    logic       beat_valid;
    logic [8:0] beat_col;
    logic       beat_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .len_code(len_code), .ileave(ileave),
        .single_wr(single_wr), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .term(term), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_last(beat_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int blen(input int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return 512;
        return 1;
    endfunction

    function automatic int exp_col(input int start, input int n, input int code,
                                   input bit il);
        int m;
        m = blen(code) - 1;
        if (code == 7 || !il)
            return ((start & ~m) | ((start + n) & m)) & 511;
        return ((start & ~m) | ((start ^ n) & m)) & 511;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int col, input bit wr);
        cmd_start = 1'b1;
        cmd_write = wr;
        cmd_col   = 9'(col);
        tick();
        cmd_start = 1'b0;
    endtask

    // Check nb beats of a finite burst, then the idle cycle after it.
    task automatic run_finite(input string req, input int start, input int code,
                              input bit il, input int nb, input int ecode);
        for (int i = 0; i < nb; i++) begin
            chk({req, " valid"}, int'(beat_valid), 1);
            chk({req, " col"}, int'(beat_col), exp_col(start, i, ecode, il));
            chk("R6 last", int'(beat_last), (i == nb - 1) ? 1 : 0);
            tick();
        end
        chk("R6 idle after last", int'(beat_valid), 0);
    endtask

    initial begin
        // R1: reset state
        tick();
        chk("R1 valid in reset", int'(beat_valid), 0);
        chk("R1 last in reset", int'(beat_last), 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 valid after reset", int'(beat_valid), 0);
        chk("R1 last after reset", int'(beat_last), 0);

        // R2 R3 R4: sweep every finite code, both orders, several columns
        for (int code = 0; code < 7; code++) begin
            for (int il = 0; il < 2; il++) begin
                for (int s = 0; s < 8; s++) begin
                    int start;
                    start = (s * 77 + 3) % 512;
                    if (s == 7) start = 511;
                    len_code = 3'(code);
                    ileave   = il[0];
                    issue(start, 1'b0);
                    run_finite(il ? "R4" : "R3 R2", start, code, il[0],
                               blen(code), code);
                end
            end
        end

        // R5 R6: full page from 500, interleave set, wraps past 511
        len_code = 3'd7;
        ileave   = 1'b1;
        issue(500, 1'b0);
        for (int i = 0; i < 530; i++) begin
            chk("R5 page valid", int'(beat_valid), 1);
            chk("R5 page col", int'(beat_col), (500 + i) % 512);
            chk("R6 no last in page", int'(beat_last), 0);
            tick();
        end
        term = 1'b1;
        tick();
        term = 1'b0;
        chk("R7 page terminated", int'(beat_valid), 0);

        // R7: terminate mid-burst and while idle
        len_code = 3'd3;
        ileave   = 1'b0;
        issue(40, 1'b0);
        tick();
        chk("R7 before term", int'(beat_col), 41);
        term = 1'b1;
        tick();
        term = 1'b0;
        chk("R7 term mid burst", int'(beat_valid), 0);
        term = 1'b1;
        tick();
        term = 1'b0;
        chk("R7 term idle valid", int'(beat_valid), 0);
        chk("R7 term idle last", int'(beat_last), 0);

        // R8: single write
        single_wr = 1'b1;
        len_code  = 3'd3;
        issue(21, 1'b1);
        run_finite("R8 single write", 21, 3, 1'b0, 1, 0);
        len_code = 3'd7;
        issue(300, 1'b1);
        run_finite("R8 single write page", 300, 7, 1'b0, 1, 0);
        len_code = 3'd3;
        ileave   = 1'b1;
        issue(21, 1'b0);
        run_finite("R8 read in single mode", 21, 3, 1'b1, 8, 3);
        single_wr = 1'b0;
        ileave    = 1'b0;
        issue(21, 1'b1);
        run_finite("R8 burst write", 21, 3, 1'b0, 8, 3);

        // R9: restart mid-burst, then start together with term
        len_code = 3'd3;
        issue(16, 1'b0);
        tick();
        tick();
        chk("R9 old burst", int'(beat_col), 18);
        len_code = 3'd2;
        ileave   = 1'b1;
        issue(102, 1'b0);
        run_finite("R9 restart", 102, 2, 1'b1, 4, 2);
        len_code = 3'd1;
        ileave   = 1'b0;
        issue(200, 1'b0);
        term = 1'b1;
        issue(77, 1'b0);
        term = 1'b0;
        run_finite("R9 start beats term", 77, 1, 1'b0, 2, 1);

        // R10: mode changes during a burst are ignored
        len_code = 3'd3;
        ileave   = 1'b0;
        issue(13, 1'b0);
        len_code  = 3'd0;
        ileave    = 1'b1;
        single_wr = 1'b1;
        run_finite("R10 mode change", 13, 3, 1'b0, 8, 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule